// File: doc/BRIEF.md
# Compressed Table-Jump Unit

This unit carries out the 16-bit compressed table-jump instruction. It owns a control register that holds a table base and a mode field. When a matching instruction arrives, the unit takes the 8-bit index from the instruction and forms an entry address from the base. It fetches that entry through a single-request instruction-side read port, clears the entry's lowest bit and returns the result as the next PC. For the upper part of the index range it also returns a link-register write that carries the address of the following instruction.

Faults are settled when the instruction is accepted. The instruction becomes an illegal-instruction result, with no memory traffic, in three cases: the extension is off, the state-enable permission is missing outside the top privilege level, or the mode field is nonzero. A read port that answers with an error gives an instruction-access fault instead of a jump. The unit raises a busy flag while a fetch is in flight. It drops a new instruction offered in that time.

Top module: `tj_unit`

## Requirements
- R1: After reset the control register reads as zero, `busy`, `res_valid` and `mem_req_valid` are low.
- R2: A control-register access at CSR address 0x017 sets `csr_hit`. A permitted write stores the full `csr_wdata` from the next clock edge, and a permitted read returns the stored value on `csr_rdata` in the same cycle. Any other address leaves `csr_hit` low.
- R3: A control-register access is permitted only when `ext_en` is 1 and either `priv_top` or `stateen_ok` is 1. Otherwise `csr_illegal` is 1 and a write leaves the register unchanged.
- R4: An instruction is matched only when bits [15:13]=101, [12:10]=000 and [1:0]=10. For any other word the unit stays idle: no busy, no request, no result. The index is bits [9:2].
- R5: If the low 6 bits of the control register (the mode field) are nonzero at acceptance, `res_valid` and `res_illegal` are 1 in the cycle after acceptance, and no memory request is made.
- R6: A matched instruction with `ext_en`=0, or with both `priv_top`=0 and `stateen_ok`=0, gives the same illegal result as R5 with no memory request.
- R7: The table base is the control register with its low 6 bits cleared. With `xlen64`=1 the request address is base + index*8 and `mem_req_dword`=1. With `xlen64`=0 it is the low 32 bits of base + index*4, zero-extended, and `mem_req_dword`=0.
- R8: On a good response `res_pc` is the returned data with bit 0 cleared. With `xlen64`=0 only the low 32 bits are used, zero-extended.
- R9: Indices 32 to 255 set `link_we` with `link_data` = pc + 2 (truncated to 32 bits when `xlen64`=0). Indices 0 to 31 leave `link_we` low.
- R10: A response with `mem_rsp_err`=1 sets `res_afault`, with `res_illegal` and `link_we` low.
- R11: `busy` is 1 from the acceptance edge until the response edge. Instructions offered while busy are ignored. The request holds its valid, address and size until `mem_req_ready`.
- R12: The result is a one-cycle pulse on `res_valid` in the cycle after the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Table-jump extension enabled |
| priv_top | input | 1 | Hart is at the highest privilege level |
| stateen_ok | input | 1 | State-enable permission bit for the jump table |
| xlen64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| csr_req | input | 1 | Control-register access request |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data (zero unless a permitted hit) |
| csr_hit | output | 1 | Access addresses this register |
| csr_illegal | output | 1 | Access faults as illegal instruction |
| insn_valid | input | 1 | Instruction offered |
| insn | input | 16 | Compressed instruction word |
| pc | input | XLEN | PC of the offered instruction |
| busy | output | 1 | Fetch in flight |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Read port accepts request |
| mem_req_addr | output | XLEN | Entry address |
| mem_req_dword | output | 1 | 1 = 64-bit load, 0 = 32-bit load |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | XLEN | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| res_valid | output | 1 | Result pulse |
| res_pc | output | XLEN | Jump target |
| res_illegal | output | 1 | Illegal-instruction result |
| res_afault | output | 1 | Instruction-access-fault result |
| link_we | output | 1 | Write return address to x1 |
| link_data | output | XLEN | Return address |

## Verification
The hardest state to reach is an instruction that arrives while a fetch is still outstanding. The bench therefore keeps a second, different table-jump word on `insn_valid` through the whole request and wait phases of one jump. It then checks that only one request was made and that the result carries the first index. Timing of the read port also matters. The bench holds back `mem_req_ready` and `mem_rsp_valid` for a number of cycles that depends on the index during a sweep of all 256 indices in both widths, so the hold-until-ready path is exercised again and again.

// File: rtl/tj_pkg.sv
package tj_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } tj_state_e;

  localparam logic [11:0] TJ_CSR_ADDR = 12'h017;
  localparam logic [2:0]  TJ_OP_HI    = 3'b101;
  localparam logic [2:0]  TJ_OP_SUB   = 3'b000;
  localparam logic [1:0]  TJ_QUAD     = 2'b10;

  function automatic logic tj_is_jump(input logic [15:0] w);
    return (w[15:13] == TJ_OP_HI) && (w[12:10] == TJ_OP_SUB) && (w[1:0] == TJ_QUAD);
  endfunction

endpackage

// File: rtl/tj_csr.sv
module tj_csr #(
  parameter int XLEN   = 64,
  parameter int MODE_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            access_ok,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic            csr_hit,
  output logic            csr_illegal,
  output logic [XLEN-1:0] csr_rdata,
  output logic [XLEN-1:0] tbl_base,
  output logic            mode_nz
);
  import tj_pkg::*;

  logic [XLEN-1:0] ctl_q, ctl_d;
  logic            wr_en;

  always_comb begin
    csr_hit     = csr_req && (csr_addr == TJ_CSR_ADDR);
    csr_illegal = csr_hit && !access_ok;
    wr_en       = csr_hit && access_ok && csr_we;
    ctl_d       = wr_en ? csr_wdata : ctl_q;
    csr_rdata   = (csr_hit && access_ok) ? ctl_q : '0;
    tbl_base    = {ctl_q[XLEN-1:MODE_W], {MODE_W{1'b0}}};
    mode_nz     = |ctl_q[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

  // R3: a refused access never changes the register
  a_r3_refused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> $stable(ctl_q));

  // R2: a permitted write is visible from the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && (csr_addr == TJ_CSR_ADDR) && access_ok) |=> (ctl_q == $past(csr_wdata)));

endmodule

// File: rtl/tj_addr.sv
module tj_addr #(
  parameter int XLEN      = 64,
  parameter int IDX_W     = 8,
  parameter int LINK_FROM = 32
) (
  input  logic [XLEN-1:0]  tbl_base,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  pc,
  input  logic             wide,
  input  logic [XLEN-1:0]  rsp_data,
  input  logic             wide_q,
  output logic [XLEN-1:0]  ent_addr,
  output logic             link_en,
  output logic [XLEN-1:0]  link_val,
  output logic [XLEN-1:0]  target
);
  localparam logic [XLEN-1:0] LO32 = XLEN'(64'h0000_0000_FFFF_FFFF);
  localparam logic [XLEN-1:0] CLR0 = ~XLEN'(1);
  localparam int              INSN_BYTES = 2;

  logic [XLEN-1:0] scaled, sum, mask_now, mask_q;

  always_comb begin
    mask_now = wide ? '1 : LO32;
    mask_q   = wide_q ? '1 : LO32;
    scaled   = wide ? (XLEN'(idx) << 3) : (XLEN'(idx) << 2);
    sum      = tbl_base + scaled;
    ent_addr = sum & mask_now;
    link_en  = (int'(idx) >= LINK_FROM);
    link_val = (pc + XLEN'(INSN_BYTES)) & mask_now;
    target   = rsp_data & mask_q & CLR0;
  end

endmodule

// File: rtl/tj_seq.sv
module tj_seq #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [15:0]     insn,
  input  logic            fault,
  input  logic            wide,
  input  logic [XLEN-1:0] ent_addr,
  input  logic            link_en,
  input  logic [XLEN-1:0] link_val,
  input  logic [XLEN-1:0] target,
  output logic            wide_q,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic            mem_req_dword,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  output logic            res_valid,
  output logic [XLEN-1:0] res_pc,
  output logic            res_illegal,
  output logic            res_afault,
  output logic            link_we,
  output logic [XLEN-1:0] link_data
);
  import tj_pkg::*;

  tj_state_e       st_q, st_d;
  logic [XLEN-1:0] addr_q, lval_q, res_pc_q, res_pc_d, link_q, link_d;
  logic            len_q;
  logic            rv_q, rv_d, ill_q, ill_d, af_q, af_d, lwe_q, lwe_d;
  logic            accept, cap_en, res_en;

  always_comb begin
    accept   = insn_valid && (st_q == ST_IDLE) && tj_is_jump(insn);
    st_d     = st_q;
    cap_en   = 1'b0;
    res_en   = 1'b0;
    rv_d     = 1'b0;
    ill_d    = 1'b0;
    af_d     = 1'b0;
    lwe_d    = 1'b0;
    res_pc_d = res_pc_q;
    link_d   = link_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (fault) begin
            rv_d  = 1'b1;
            ill_d = 1'b1;
          end else begin
            st_d   = ST_REQ;
            cap_en = 1'b1;
          end
        end
      end
      ST_REQ: begin
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          st_d   = ST_IDLE;
          rv_d   = 1'b1;
          res_en = 1'b1;
          if (mem_rsp_err) begin
            af_d = 1'b1;
          end else begin
            res_pc_d = target;
            lwe_d    = len_q;
            link_d   = lval_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rv_q  <= 1'b0;
      ill_q <= 1'b0;
      af_q  <= 1'b0;
      lwe_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rv_q  <= rv_d;
      ill_q <= ill_d;
      af_q  <= af_d;
      lwe_q <= lwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lval_q <= '0;
      len_q  <= 1'b0;
      wide_q <= 1'b0;
    end else if (cap_en) begin
      addr_q <= ent_addr;
      lval_q <= link_val;
      len_q  <= link_en;
      wide_q <= wide;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pc_q <= '0;
      link_q   <= '0;
    end else if (res_en) begin
      res_pc_q <= res_pc_d;
      link_q   <= link_d;
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_dword = wide_q;
  assign res_valid     = rv_q;
  assign res_illegal   = ill_q;
  assign res_afault    = af_q;
  assign res_pc        = res_pc_q;
  assign link_we       = lwe_q;
  assign link_data     = link_q;

  // R11: request held until taken
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_dword)));

  // R12: a non-illegal result follows a taken response
  a_r12_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_illegal) |-> $past(mem_rsp_valid));

  // R9: link write only on a clean jump
  a_r9_link_clean: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (res_valid && !res_illegal && !res_afault));

  // R8: jump target is halfword aligned
  a_r8_target_even: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_illegal && !res_afault) |-> !res_pc[0]);

  // R5: an illegal result comes with no memory request
  a_r5_fault_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> !mem_req_valid);

endmodule

// File: rtl/tj_unit.sv
module tj_unit #(
  parameter int XLEN      = 64,
  parameter int MODE_W    = 6,
  parameter int IDX_W     = 8,
  parameter int LINK_FROM = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_en,
  input  logic            priv_top,
  input  logic            stateen_ok,
  input  logic            xlen64,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  output logic            csr_illegal,
  input  logic            insn_valid,
  input  logic [15:0]     insn,
  input  logic [XLEN-1:0] pc,
  output logic            busy,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic            mem_req_dword,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            res_valid,
  output logic [XLEN-1:0] res_pc,
  output logic            res_illegal,
  output logic            res_afault,
  output logic            link_we,
  output logic [XLEN-1:0] link_data
);
  localparam int IDX_LSB = 2;

  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic             perm_ok, access_ok, mode_nz, fault;
  logic             link_en, wide_q;
  logic [XLEN-1:0]  tbl_base, ent_addr, link_val, target;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    perm_ok   = priv_top || stateen_ok;
    access_ok = ext_en && perm_ok;
    fault     = !access_ok || mode_nz;
    idx       = insn[IDX_LSB +: IDX_W];
  end

  tj_csr #(.XLEN(XLEN), .MODE_W(MODE_W)) u_csr (
    .clk(clk), .rst_n(rst_s_n), .access_ok(access_ok),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_hit(csr_hit), .csr_illegal(csr_illegal), .csr_rdata(csr_rdata),
    .tbl_base(tbl_base), .mode_nz(mode_nz)
  );

  tj_addr #(.XLEN(XLEN), .IDX_W(IDX_W), .LINK_FROM(LINK_FROM)) u_addr (
    .tbl_base(tbl_base), .idx(idx), .pc(pc), .wide(xlen64),
    .rsp_data(mem_rsp_data), .wide_q(wide_q),
    .ent_addr(ent_addr), .link_en(link_en), .link_val(link_val), .target(target)
  );

  tj_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_s_n),
    .insn_valid(insn_valid), .insn(insn), .fault(fault), .wide(xlen64),
    .ent_addr(ent_addr), .link_en(link_en), .link_val(link_val), .target(target),
    .wide_q(wide_q), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_dword(mem_req_dword),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_pc(res_pc), .res_illegal(res_illegal),
    .res_afault(res_afault), .link_we(link_we), .link_data(link_data)
  );

  // R6: missing permission never produces a request on acceptance
  a_r6_no_perm_no_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    (insn_valid && !busy && tj_pkg::tj_is_jump(insn) && !access_ok) |=> !mem_req_valid);

endmodule

// File: tb/tj_unit_test.sv
module tj_unit_test;
  localparam int XLEN = 64;
  localparam time CLK_PERIOD = 10;
  localparam logic [63:0] LO32 = 64'h0000_0000_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_en, priv_top, stateen_ok, xlen64;
  logic csr_req, csr_we;
  logic [11:0] csr_addr;
  logic [XLEN-1:0] csr_wdata, csr_rdata;
  logic csr_hit, csr_illegal;
  logic insn_valid;
  logic [15:0] insn;
  logic [XLEN-1:0] pc;
  logic busy, mem_req_valid, mem_req_ready, mem_req_dword;
  logic [XLEN-1:0] mem_req_addr, mem_rsp_data, res_pc, link_data;
  logic mem_rsp_valid, mem_rsp_err;
  logic res_valid, res_illegal, res_afault, link_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] ctl_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  tj_unit uut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .priv_top(priv_top),
    .stateen_ok(stateen_ok), .xlen64(xlen64),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_hit(csr_hit), .csr_illegal(csr_illegal),
    .insn_valid(insn_valid), .insn(insn), .pc(pc), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_dword(mem_req_dword),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_pc(res_pc), .res_illegal(res_illegal),
    .res_afault(res_afault), .link_we(link_we), .link_data(link_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ {a[31:0], a[63:32]};
  endfunction

  function automatic logic [15:0] enc(input int idx);
    return {3'b101, 3'b000, 8'(idx), 2'b10};
  endfunction

  task automatic csr_write(input logic [11:0] a, input logic [63:0] v);
    @(negedge clk);
    csr_req = 1; csr_we = 1; csr_addr = a; csr_wdata = v;
    @(negedge clk);
    csr_req = 0; csr_we = 0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [63:0] v, output logic hit, output logic ill);
    @(negedge clk);
    csr_req = 1; csr_we = 0; csr_addr = a;
    #1;
    v = csr_rdata; hit = csr_hit; ill = csr_illegal;
    @(negedge clk);
    csr_req = 0;
  endtask

  // one table jump with port-side memory model
  task automatic run_jump(input int idx, input logic [63:0] pcv, input bit err, input bit poke,
                          input int rdly, input int sdly);
    logic [63:0] base, exp_addr, exp_tgt, exp_lnk, got_addr;
    bit stable_ok;
    base = ctl_v & ~64'h3F;
    exp_addr = xlen64 ? base + 64'(idx) * 8 : (base + 64'(idx) * 4) & LO32;
    @(negedge clk);
    insn = enc(idx); pc = pcv; insn_valid = 1;
    @(negedge clk);
    if (poke) insn = enc((idx + 37) % 256);
    else      insn_valid = 0;
    chk(busy === 1'b1, "R11 busy after accept", 64'(busy), 64'd1);
    chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R7 entry address",
        mem_req_addr, exp_addr);
    chk(mem_req_dword === xlen64, "R7 load size", 64'(mem_req_dword), 64'(xlen64));
    got_addr = mem_req_addr;
    stable_ok = 1;
    for (int k = 0; k < rdly; k++) begin
      @(negedge clk);
      if (!(mem_req_valid === 1'b1 && mem_req_addr === got_addr)) stable_ok = 0;
    end
    if (rdly > 0) chk(stable_ok, "R11 request held", mem_req_addr, got_addr);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    for (int k = 0; k < sdly; k++) @(negedge clk);
    chk(res_valid === 1'b0 && busy === 1'b1, "R12 no early result", 64'(res_valid), 64'd0);
    mem_rsp_valid = 1; mem_rsp_err = err; mem_rsp_data = mem_fn(got_addr);
    insn_valid = 0;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_err = 0;
    exp_tgt = (xlen64 ? mem_fn(got_addr) : (mem_fn(got_addr) & LO32)) & ~64'h1;
    exp_lnk = xlen64 ? pcv + 64'd2 : (pcv + 64'd2) & LO32;
    chk(res_valid === 1'b1 && busy === 1'b0, "R12 result pulse", 64'(res_valid), 64'd1);
    if (err) begin
      chk(res_afault === 1'b1 && res_illegal === 1'b0 && link_we === 1'b0,
          "R10 access fault", {61'd0, res_afault, res_illegal, link_we}, 64'b100);
    end else begin
      chk(res_pc === exp_tgt && res_afault === 1'b0 && res_illegal === 1'b0,
          "R8 jump target", res_pc, exp_tgt);
      if (idx >= 32)
        chk(link_we === 1'b1 && link_data === exp_lnk, "R9 link written", link_data, exp_lnk);
      else
        chk(link_we === 1'b0, "R9 no link low index", 64'(link_we), 64'd0);
    end
    @(negedge clk);
    chk(res_valid === 1'b0 && mem_req_valid === 1'b0 && busy === 1'b0,
        poke ? "R11 busy-time insn ignored" : "R12 single pulse",
        {62'd0, res_valid, mem_req_valid}, 64'd0);
  endtask

  task automatic run_fault(input int idx, input string req);
    @(negedge clk);
    insn = enc(idx); pc = 64'h1000; insn_valid = 1;
    @(negedge clk);
    insn_valid = 0;
    chk(res_valid === 1'b1 && res_illegal === 1'b1 && mem_req_valid === 1'b0 && busy === 1'b0,
        req, {60'd0, res_valid, res_illegal, mem_req_valid, busy}, 64'b1100);
  endtask

  task automatic run_ignore(input logic [15:0] w);
    @(negedge clk);
    insn = w; insn_valid = 1;
    @(negedge clk);
    insn_valid = 0;
    chk(busy === 1'b0 && mem_req_valid === 1'b0 && res_valid === 1'b0,
        "R4 non-matching word ignored", {61'd0, busy, mem_req_valid, res_valid}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic h, il;
    rst_n = 0; ext_en = 1; priv_top = 1; stateen_ok = 0; xlen64 = 1;
    csr_req = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    insn_valid = 0; insn = '0; pc = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0; mem_rsp_err = 0;
    ctl_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1
    chk(busy === 1'b0 && res_valid === 1'b0 && mem_req_valid === 1'b0, "R1 idle after reset",
        {61'd0, busy, res_valid, mem_req_valid}, 64'd0);
    csr_read(12'h017, v, h, il);
    chk(v === 64'd0 && h === 1'b1, "R1 register clear", v, 64'd0);

    // R2
    ctl_v = 64'h0000_0012_3456_7840;
    csr_write(12'h017, ctl_v);
    csr_read(12'h017, v, h, il);
    chk(v === ctl_v && il === 1'b0, "R2 readback", v, ctl_v);
    csr_read(12'h018, v, h, il);
    chk(h === 1'b0 && il === 1'b0, "R2 other address no hit", 64'(h), 64'd0);
    csr_write(12'h016, 64'hFFFF);
    csr_read(12'h017, v, h, il);
    chk(v === ctl_v, "R2 other address no write", v, ctl_v);

    // R3
    ext_en = 0;
    csr_read(12'h017, v, h, il);
    chk(il === 1'b1 && v === 64'd0, "R3 disabled access illegal", 64'(il), 64'd1);
    csr_write(12'h017, 64'hDEAD_BEEF_0000_0000);
    ext_en = 1; priv_top = 0; stateen_ok = 0;
    csr_read(12'h017, v, h, il);
    chk(il === 1'b1, "R3 missing permission illegal", 64'(il), 64'd1);
    csr_write(12'h017, 64'h0BAD_0000_0000_0000);
    stateen_ok = 1;
    csr_read(12'h017, v, h, il);
    chk(il === 1'b0 && v === ctl_v, "R3 refused writes dropped", v, ctl_v);

    // R4
    run_ignore(16'b101_001_00000001_10);
    run_ignore(16'b101_000_00000001_01);
    run_ignore(16'b100_000_00000001_10);
    run_ignore(16'b101_100_00100001_10);

    // R5
    csr_write(12'h017, ctl_v | 64'h5);
    run_fault(40, "R5 mode nonzero illegal");
    csr_write(12'h017, ctl_v | 64'h20);
    run_fault(3, "R5 mode top bit illegal");
    csr_write(12'h017, ctl_v);

    // R6
    ext_en = 0;
    run_fault(7, "R6 extension off illegal");
    ext_en = 1; priv_top = 0; stateen_ok = 0;
    run_fault(50, "R6 permission missing illegal");
    stateen_ok = 1;

    // R10
    run_jump(33, 64'h2000, 1, 0, 1, 0);
    run_jump(4, 64'h2002, 1, 0, 0, 2);

    // R11 second instruction offered while busy
    run_jump(70, 64'h3000, 0, 1, 2, 1);

    // full index sweep in both widths (R7, R8, R9, R11, R12)
    for (int m = 1; m >= 0; m--) begin
      xlen64 = m[0];
      for (int i = 0; i < 256; i++) begin
        priv_top = i[0];
        stateen_ok = ~i[0] | i[1];
        if (!priv_top) stateen_ok = 1;
        run_jump(i, 64'h0000_0000_FFFF_FF00 + 64'(i) * 2, 0, 0, i % 3, i % 2);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule